// File: doc/BRIEF.md
# Two-time-programmable setting controller

This block keeps the 8-bit wiper code of a digital resistor and applies the control bits of the most recent instruction byte to it. A serial front end hands it a strobed instruction byte and strobed data bytes. The block returns three things: the code the resistor network should use, a shutdown flag, and two status bits that a read can return. Two one-shot fuse arrays are modelled with register flags. The first array can be burned once. The second array can then be burned once as well. If the second array is burned first, the first array can never be used.

Once an array has been burned, the code is pinned to the fused value. An overwrite mode can move the code away from the fused value for a while. When overwrite ends, the code falls back to the fused value. Shutdown parks the wiper but keeps taking new settings, and the stored setting takes effect when shutdown ends. A power-on reset clears every volatile control. The fuse flags and the fused value are kept across that reset, and a separate fuse-clear input exists only so the bench can return the arrays to the unburned state.

Top module: `ttp_setting_ctrl`

## Requirements
- R1: After a power-on reset with no array burned, wiper_code is 0x80, shutdown is 0 and status is 2'b00.
- R2: When no array is burned, a data write under an instruction with bit 5 clear sets wiper_code to the data byte on the next clock.
- R3: An instruction byte with bit 4 set is discarded. The control bits of the previous instruction stay in force.
- R4: An instruction with bit 6 set raises shutdown and drives wiper_code to 0x00. Data writes during shutdown are stored, and the last one appears on wiper_code once an instruction with bit 6 clear is loaded.
- R5: A data write under an instruction with bit 5 set burns the array chosen by bit 7 (0 = first, 1 = second) with the data byte. The write sets status[0] for the first array or status[1] for the second, and wiper_code becomes the data byte.
- R6: A burn request is ignored, with status and wiper_code unchanged, in two cases: the chosen array is already burned, or the first array is chosen after the second has been burned.
- R7: While any array is burned and overwrite (instruction bit 3) is clear, data writes with bit 5 clear leave wiper_code at the fused value.
- R8: While overwrite is set, data writes with bit 5 clear change wiper_code even when an array is burned. Loading an instruction with bit 3 clear then returns wiper_code to the most recent fused value.
- R9: A power-on reset with an array burned sets wiper_code to the most recent fused value and clears shutdown and overwrite. Status is not changed.
- R10: Asserting fuse_clr, with a power-on reset, clears both status bits and the fused state, so wiper_code comes up at 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous power-on reset of the volatile state |
| fuse_clr | input | 1 | Synchronous clear of the emulated fuse arrays (bench only) |
| instr_load | input | 1 | Strobe: instr_byte holds a new instruction |
| instr_byte | input | 8 | Instruction: bit 7 array select, bit 6 shutdown, bit 5 burn, bit 4 must be 0, bit 3 overwrite |
| data_wr | input | 1 | Strobe: data_byte holds a new setting |
| data_byte | input | 8 | New wiper setting |
| wiper_code | output | 8 | Effective code sent to the resistor network |
| shutdown | output | 1 | Open terminal A and tie the wiper to terminal B |
| status | output | 2 | Burn status: bit 0 first array, bit 1 second array |

## Verification
A wrong fuse flag shows up on status one clock after the write that set it. It also changes how the next volatile write or burn request is handled, so wiper_code either holds or moves where the model expects the opposite. A corrupted stored setting stays hidden while shutdown holds wiper_code at zero. It shows up in the first cycle after shutdown is released, or in the first cycle after a power-on reset, which reloads the fused value. A stale overwrite flag shows up only on the next volatile write or overwrite release, so each of those events is checked the cycle after it happens.

// File: rtl/ttp_pkg.sv
package ttp_pkg;
    // Instruction byte field positions decoded by this block.
    localparam int unsigned IB_SEL2 = 7;
    localparam int unsigned IB_SD   = 6;
    localparam int unsigned IB_PROG = 5;
    localparam int unsigned IB_RSVD = 4;
    localparam int unsigned IB_OW   = 3;
    localparam int unsigned NUM_ARRAYS = 2;

    typedef struct packed {
        logic sel2;
        logic sd;
        logic prog;
        logic ow;
    } ttp_ctl_t;
endpackage

// File: rtl/ttp_instr_dec.sv
module ttp_instr_dec
    import ttp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       instr_load,
    input  logic [7:0] instr_byte,
    output ttp_ctl_t   ctl,
    output logic       ow_release
);
    ttp_ctl_t ctl_d, ctl_q;
    logic     accept;

    always_comb begin
        ctl_d      = ctl_q;
        ow_release = 1'b0;
        accept     = instr_load && !instr_byte[IB_RSVD];
        if (!rst_n) begin
            ctl_d = '0;
        end else if (accept) begin
            ctl_d.sel2 = instr_byte[IB_SEL2];
            ctl_d.sd   = instr_byte[IB_SD];
            ctl_d.prog = instr_byte[IB_PROG];
            ctl_d.ow   = instr_byte[IB_OW];
            ow_release = ctl_q.ow && !instr_byte[IB_OW];
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/ttp_fuse_bank.sv
module ttp_fuse_bank
    import ttp_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic                  clk,
    input  logic                  fuse_clr,
    input  logic                  prog_req,
    input  logic                  sel2,
    input  logic [W-1:0]          wr_data,
    output logic [NUM_ARRAYS-1:0] used,
    output logic [W-1:0]          fused_val,
    output logic                  prog_ok
);
    typedef struct packed {
        logic [NUM_ARRAYS-1:0] used;
        logic [W-1:0]          val;
    } fuse_st_t;

    fuse_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // The second array may be burned once. The first only while nothing is burned.
        prog_ok = !fuse_clr && prog_req &&
                  (sel2 ? !st_q.used[1] : (st_q.used == '0));
        if (fuse_clr) begin
            st_d = '0;
        end else if (prog_ok) begin
            st_d.used[sel2] = 1'b1;
            st_d.val        = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign used      = st_q.used;
    assign fused_val = st_q.val;
endmodule

// File: rtl/ttp_setting_ctrl.sv
module ttp_setting_ctrl
    import ttp_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fuse_clr,
    input  logic                  instr_load,
    input  logic [7:0]            instr_byte,
    input  logic                  data_wr,
    input  logic [W-1:0]          data_byte,
    output logic [W-1:0]          wiper_code,
    output logic                  shutdown,
    output logic [NUM_ARRAYS-1:0] status
);
    localparam logic [W-1:0] MID_CODE = {1'b1, {(W-1){1'b0}}};

    ttp_ctl_t              ctl;
    logic                  ow_release;
    logic [NUM_ARRAYS-1:0] used;
    logic [W-1:0]          fused_val;
    logic                  prog_ok;
    logic                  prog_req;
    logic                  locked;
    logic [W-1:0]          vol_d, vol_q;

    ttp_instr_dec u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .instr_load (instr_load),
        .instr_byte (instr_byte),
        .ctl        (ctl),
        .ow_release (ow_release)
    );

    assign prog_req = rst_n && data_wr && ctl.prog;

    ttp_fuse_bank #(.W(W)) u_fuse (
        .clk       (clk),
        .fuse_clr  (fuse_clr),
        .prog_req  (prog_req),
        .sel2      (ctl.sel2),
        .wr_data   (data_byte),
        .used      (used),
        .fused_val (fused_val),
        .prog_ok   (prog_ok)
    );

    always_comb begin
        locked = |used;
        vol_d  = vol_q;
        if (!rst_n) begin
            vol_d = locked ? fused_val : MID_CODE;
        end else if (prog_ok) begin
            vol_d = data_byte;
        end else if (data_wr && !ctl.prog && (!locked || ctl.ow)) begin
            vol_d = data_byte;
        end else if (ow_release && locked) begin
            vol_d = fused_val;
        end
    end

    always_ff @(posedge clk) begin
        vol_q <= vol_d;
    end

    assign shutdown   = ctl.sd;
    assign wiper_code = ctl.sd ? '0 : vol_q;
    assign status     = used;
endmodule

// File: rtl/ttp_setting_ctrl_chk.sv
module ttp_setting_ctrl_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         fuse_clr,
    input logic         instr_load,
    input logic [7:0]   instr_byte,
    input logic [W-1:0] wiper_code,
    input logic         shutdown,
    input logic [1:0]   status,
    input logic         ow_act
);
    localparam logic [W-1:0] MID_CODE = {1'b1, {(W-1){1'b0}}};

    // R1: leaving reset with nothing burned gives midscale, not shut down
    a_r1_reset_midscale: assert property (@(posedge clk) disable iff (fuse_clr)
        ($rose(rst_n) && status == 2'b00) |-> (wiper_code == MID_CODE && !shutdown));

    // R3: an instruction with the reserved bit set changes no control state
    a_r3_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n || fuse_clr)
        (instr_load && instr_byte[4]) |=> ($stable(shutdown) && $stable(ow_act)));

    // R4: shutdown only rises after an accepted instruction with bit 6 set
    a_r4_shutdown_cause: assert property (@(posedge clk) disable iff (!rst_n || fuse_clr)
        $rose(shutdown) |-> $past(instr_load && instr_byte[6] && !instr_byte[4]));

    // R5: status bits never clear without fuse_clr
    a_r5_status_sticky: assert property (@(posedge clk) disable iff (!rst_n || fuse_clr)
        ((status & $past(status)) == $past(status)));

    // R6: first array stays unusable once the second was burned first
    a_r6_first_lockout: assert property (@(posedge clk) disable iff (!rst_n || fuse_clr)
        ($past(status) == 2'b10) |-> (status == 2'b10));

    // R7: burned, no overwrite, no new burn, no shutdown: code holds
    a_r7_locked_hold: assert property (@(posedge clk) disable iff (!rst_n || fuse_clr)
        ((|$past(status)) && status == $past(status) && !shutdown && !$past(shutdown)
         && !$past(ow_act)) |-> (wiper_code == $past(wiper_code)));
endmodule

bind ttp_setting_ctrl ttp_setting_ctrl_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fuse_clr   (fuse_clr),
    .instr_load (instr_load),
    .instr_byte (instr_byte),
    .wiper_code (wiper_code),
    .shutdown   (shutdown),
    .status     (status),
    .ow_act     (ctl.ow)
);

// File: tb/ttp_setting_ctrl_test.sv
module ttp_setting_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fuse_clr = 1'b1;
    logic       instr_load = 1'b0;
    logic [7:0] instr_byte = 8'h00;
    logic       data_wr = 1'b0;
    logic [7:0] data_byte = 8'h00;
    logic [7:0] wiper_code;
    logic       shutdown;
    logic [1:0] status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic       m_sel2, m_sd, m_prog, m_ow;
    logic [1:0] m_u;
    logic [7:0] m_fused, m_vol;

    always #2.5 clk = ~clk;

    ttp_setting_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fuse_clr(fuse_clr),
        .instr_load(instr_load), .instr_byte(instr_byte),
        .data_wr(data_wr), .data_byte(data_byte),
        .wiper_code(wiper_code), .shutdown(shutdown), .status(status)
    );

    function automatic logic [7:0] exp_wiper();
        return m_sd ? 8'h00 : m_vol;
    endfunction

    task automatic check_lit(string req, logic [7:0] ew, logic es, logic [1:0] est);
        checks++;
        if (wiper_code !== ew || shutdown !== es || status !== est) begin
            errors++;
            $display("FAIL %s: wiper=%h sd=%b st=%b expected wiper=%h sd=%b st=%b",
                     req, wiper_code, shutdown, status, ew, es, est);
        end
    endtask

    task automatic check_model(string req);
        check_lit(req, exp_wiper(), m_sd, m_u);
    endtask

    task automatic send_instr(input logic [7:0] b);
        @(negedge clk); instr_load = 1'b1; instr_byte = b;
        @(negedge clk); instr_load = 1'b0;
        if (!b[4]) begin
            if (m_ow && !b[3] && m_u != 2'b00) m_vol = m_fused;
            m_sel2 = b[7]; m_sd = b[6]; m_prog = b[5]; m_ow = b[3];
        end
    endtask

    task automatic send_data(input logic [7:0] d);
        @(negedge clk); data_wr = 1'b1; data_byte = d;
        @(negedge clk); data_wr = 1'b0;
        if (m_prog) begin
            if (m_sel2 ? !m_u[1] : (m_u == 2'b00)) begin
                m_u[m_sel2] = 1'b1; m_fused = d; m_vol = d;
            end
        end else if (m_u == 2'b00 || m_ow) begin
            m_vol = d;
        end
    endtask

    task automatic power_reset(input logic clr);
        @(negedge clk); rst_n = 1'b0; fuse_clr = clr;
        @(negedge clk);
        @(negedge clk); fuse_clr = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        if (clr) begin m_u = 2'b00; m_fused = 8'h00; end
        m_vol = (m_u != 2'b00) ? m_fused : 8'h80;
        m_sel2 = 1'b0; m_sd = 1'b0; m_prog = 1'b0; m_ow = 1'b0;
    endtask

    initial begin
        #500000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240125));
        m_u = 2'b00; m_fused = 8'h00;
        power_reset(1'b1);
        check_lit("R1 reset", 8'h80, 1'b0, 2'b00);

        send_instr(8'h00); send_data(8'h3C);
        check_lit("R2 volatile write", 8'h3C, 1'b0, 2'b00);

        send_instr(8'h50);
        check_lit("R3 reserved bit instruction", 8'h3C, 1'b0, 2'b00);
        send_data(8'h11);
        check_lit("R3 previous control kept", 8'h11, 1'b0, 2'b00);

        send_instr(8'h40);
        check_lit("R4 shutdown entry", 8'h00, 1'b1, 2'b00);
        send_data(8'h5A);
        check_lit("R4 write in shutdown hidden", 8'h00, 1'b1, 2'b00);
        send_instr(8'h00);
        check_lit("R4 release applies stored", 8'h5A, 1'b0, 2'b00);

        send_instr(8'h20); send_data(8'hA7);
        check_lit("R5 burn first array", 8'hA7, 1'b0, 2'b01);

        send_instr(8'h00); send_data(8'h01);
        check_lit("R7 locked volatile write ignored", 8'hA7, 1'b0, 2'b01);

        send_instr(8'h08); send_data(8'h22);
        check_lit("R8 overwrite write", 8'h22, 1'b0, 2'b01);
        send_instr(8'h00);
        check_lit("R8 overwrite release reverts", 8'hA7, 1'b0, 2'b01);

        send_instr(8'h20); send_data(8'h33);
        check_lit("R6 reburn first rejected", 8'hA7, 1'b0, 2'b01);

        power_reset(1'b0);
        check_lit("R9 reset keeps fused", 8'hA7, 1'b0, 2'b01);

        send_instr(8'hA0); send_data(8'h64);
        check_lit("R5 burn second array", 8'h64, 1'b0, 2'b11);

        send_instr(8'h48); send_data(8'h99);
        power_reset(1'b0);
        check_lit("R9 reset clears shutdown and overwrite", 8'h64, 1'b0, 2'b11);
        send_data(8'h12);
        check_lit("R9 overwrite cleared by reset", 8'h64, 1'b0, 2'b11);

        power_reset(1'b1);
        check_lit("R10 fuse clear", 8'h80, 1'b0, 2'b00);

        send_instr(8'hA0); send_data(8'h0F);
        check_lit("R5 second array first", 8'h0F, 1'b0, 2'b10);
        send_instr(8'h20); send_data(8'h77);
        check_lit("R6 first array locked out", 8'h0F, 1'b0, 2'b10);
        send_instr(8'hA0); send_data(8'h78);
        check_lit("R6 reburn second rejected", 8'h0F, 1'b0, 2'b10);

        for (int i = 0; i < 600; i++) begin
            int unsigned op;
            op = $urandom_range(0, 19);
            if (op < 7) begin
                logic [7:0] b;
                b = 8'($urandom);
                b[4] = ($urandom_range(0, 7) == 0);
                b[5] = ($urandom_range(0, 5) == 0);
                send_instr(b);
            end else if (op < 19) begin
                send_data(8'($urandom));
            end else begin
                power_reset($urandom_range(0, 2) == 0);
            end
            check_model("R2 R4 R5 R6 R7 R8 R9 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule